// File: doc/BRIEF.md
# Variable-Length Instruction Record Parser

This block reads an instruction byte stream, one byte per accepted beat, and splits it into whole instructions. It looks at the first byte to classify the opcode. From the mode and register bits it then works out how many more bytes belong to the instruction. It collects the optional addressing byte, the displacement bytes and the immediate bytes, then presents one record per instruction.

A record holds the first byte, the direction, width and sign-extend bits, the addressing fields, a 16-bit displacement, a 16-bit immediate and the byte count. A fetch stage drives bytes in on a valid/ready port. A decode stage takes records from a second valid/ready port. The parser waits while a record is pending, so the record is back-pressured without being lost.

The parser handles four kinds of encoding:
- register/memory ALU forms;
- the immediate group;
- move-immediate-to-register;
- register increment, in both its one-byte and two-byte forms.

Any other first byte is reported as a one-byte error record. Parsing then starts again at the next byte.

Top module: `instr_len_parser`

## Requirements
- R1: While `rst` is high at a rising clock edge, the parser returns to its opcode state. After that edge `out_valid` is 0 and `in_ready` is 1, and any instruction that was only partly received is dropped.
- R2: A first byte of the form 01000rrr is a complete one-byte instruction. Its record has length 1, `out_reg`=rrr, `out_w`=1 and `out_has_modrm`=0.
- R3: A first byte of the form 00xxx0dw takes one addressing byte. The record gives `out_d`=d and `out_w`=w, and takes `out_mod`, `out_reg` and `out_rm` from bits 7:6, 5:3 and 2:0 of that byte.
- R4: The number of displacement bytes after the addressing byte is set by mod and rm:
  - mod=00: none, except rm=110, which takes two;
  - mod=01: one byte, sign-extended to 16 bits;
  - mod=10: two bytes, low byte first;
  - mod=11: none.
  When there is no displacement, `out_disp` is 0.
- R5: First bytes 100000sw (immediate group) take an addressing byte, then the displacement as in R4, then the immediate:
  - sw=00: one immediate byte, zero-extended;
  - sw=01: two immediate bytes, low byte first;
  - sw=11: one immediate byte, sign-extended.
  `out_s` reports s, and `out_reg` carries the operation extension.
- R6: A first byte 1011wrrr takes no addressing byte. It takes one immediate byte when w=0 (zero-extended) and two when w=1 (low byte first). The record reports `out_reg`=rrr and `out_w`=w.
- R7: First bytes FE and FF take an addressing byte and a displacement as in R4, with no immediate. `out_w` is the low bit of the first byte.
- R8: A first byte outside R2, R3, R5, R6 and R7, including 100000 with sw=10, gives a record with `out_err`=1, length 1 and `out_has_modrm`=0. The next byte is parsed as a new first byte.
- R9: `in_ready` is 0 while `out_valid` is 1. A pending record stays unchanged until `out_ready` is 1. No input byte is taken or lost during the stall.
- R10: `out_len` equals the number of bytes accepted for the instruction, and lies between 1 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is present |
| in_byte | input | 8 | Instruction stream byte |
| in_ready | output | 1 | Parser accepts a byte this cycle |
| out_valid | output | 1 | Instruction record is pending |
| out_ready | input | 1 | Consumer takes the record |
| out_opcode | output | 8 | First byte of the instruction |
| out_len | output | 3 | Instruction length in bytes |
| out_err | output | 1 | Unsupported first byte |
| out_has_modrm | output | 1 | An addressing byte was present |
| out_d | output | 1 | Direction bit (ALU forms) |
| out_w | output | 1 | Word/byte width bit |
| out_s | output | 1 | Sign-extend bit (immediate group) |
| out_mod | output | 2 | Addressing mode field |
| out_reg | output | 3 | Register field, or operation extension |
| out_rm | output | 3 | Register/memory field |
| out_disp | output | 16 | Displacement, assembled or sign-extended |
| out_imm | output | 16 | Immediate, assembled or extended |

## Verification
The hardest case to reach from the ports is a full six-byte instruction: an immediate-group word form with a 16-bit displacement. In that case every state of the parser is visited in one record, and the length count must reach its maximum. The stimulus table contains that instruction. It also contains the direct-address case of mod=00 with rm=110, which takes two displacement bytes even though its mode suggests none. Resynchronisation is tested by placing error bytes directly ahead of valid instructions in the same stream. Back-pressure is tested by holding a new byte on the input while a record stalls for several cycles.

// File: rtl/instr_len_parser.sv
module instr_len_parser (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  output logic        in_ready,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_opcode,
  output logic [2:0]  out_len,
  output logic        out_err,
  output logic        out_has_modrm,
  output logic        out_d,
  output logic        out_w,
  output logic        out_s,
  output logic [1:0]  out_mod,
  output logic [2:0]  out_reg,
  output logic [2:0]  out_rm,
  output logic [15:0] out_disp,
  output logic [15:0] out_imm
);
  typedef enum logic [2:0] {S_OPC, S_MODRM, S_DLO, S_DHI, S_ILO, S_IHI, S_EMIT} st_t;

  st_t         st;
  logic [7:0]  opc_q, modrm_q;
  logic [15:0] disp_q, imm_q;
  logic [2:0]  len_q;
  logic [1:0]  dcnt_q, icnt_q;
  logic        sext_q, err_q;

  assign in_ready  = (st != S_EMIT);
  assign out_valid = (st == S_EMIT);
  wire take = in_valid && in_ready;

  wire b_alu = (in_byte[7:6] == 2'b00) && !in_byte[2];
  wire b_grp = (in_byte[7:2] == 6'b100000) && (in_byte[1:0] != 2'b10);
  wire b_mov = (in_byte[7:4] == 4'b1011);
  wire b_inc = (in_byte[7:3] == 5'b01000);
  wire b_ff  = (in_byte[7:1] == 7'b1111111);
  wire [1:0] b_dcnt = (in_byte[7:6] == 2'b01) ? 2'd1 :
                      (in_byte[7:6] == 2'b10) ? 2'd2 :
                      (in_byte[7:6] == 2'b00 && in_byte[2:0] == 3'b110) ? 2'd2 : 2'd0;
  wire [15:0] b_sx = {{8{in_byte[7]}}, in_byte};
  wire [15:0] b_zx = {8'h00, in_byte};

  wire q_alu = (opc_q[7:6] == 2'b00) && !opc_q[2];
  wire q_grp = (opc_q[7:2] == 6'b100000);
  wire q_mov = (opc_q[7:4] == 4'b1011);
  wire q_inc = (opc_q[7:3] == 5'b01000);
  wire q_ff  = (opc_q[7:1] == 7'b1111111);
  wire has_m = !err_q && (q_alu || q_grp || q_ff);

  assign out_opcode    = opc_q;
  assign out_len       = len_q;
  assign out_err       = err_q;
  assign out_has_modrm = has_m;
  assign out_disp      = disp_q;
  assign out_imm       = imm_q;
  assign out_mod       = has_m ? modrm_q[7:6] : 2'b00;
  assign out_rm        = has_m ? modrm_q[2:0] : 3'b000;
  assign out_reg       = has_m ? modrm_q[5:3] : opc_q[2:0];
  assign out_w         = q_mov ? opc_q[3] : (q_inc ? 1'b1 : opc_q[0]);
  assign out_d         = !err_q && q_alu && opc_q[1];
  assign out_s         = !err_q && q_grp && opc_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_OPC;
      opc_q <= '0; modrm_q <= '0; disp_q <= '0; imm_q <= '0;
      len_q <= '0; dcnt_q <= '0; icnt_q <= '0; sext_q <= 1'b0; err_q <= 1'b0;
    end else begin
      case (st)
        S_OPC: if (take) begin
          opc_q <= in_byte; modrm_q <= '0; disp_q <= '0; imm_q <= '0;
          len_q <= 3'd1; dcnt_q <= '0; icnt_q <= '0; sext_q <= 1'b0; err_q <= 1'b0;
          if (b_inc) st <= S_EMIT;
          else if (b_mov) begin
            icnt_q <= in_byte[3] ? 2'd2 : 2'd1;
            st <= S_ILO;
          end else if (b_alu || b_ff) st <= S_MODRM;
          else if (b_grp) begin
            icnt_q <= (in_byte[1:0] == 2'b01) ? 2'd2 : 2'd1;
            sext_q <= in_byte[1];
            st <= S_MODRM;
          end else begin
            err_q <= 1'b1;
            st <= S_EMIT;
          end
        end
        S_MODRM: if (take) begin
          modrm_q <= in_byte;
          len_q <= len_q + 3'd1;
          dcnt_q <= b_dcnt;
          st <= (b_dcnt != 2'd0) ? S_DLO : ((icnt_q != 2'd0) ? S_ILO : S_EMIT);
        end
        S_DLO: if (take) begin
          disp_q <= (dcnt_q == 2'd1) ? b_sx : b_zx;
          len_q <= len_q + 3'd1;
          st <= (dcnt_q == 2'd2) ? S_DHI : ((icnt_q != 2'd0) ? S_ILO : S_EMIT);
        end
        S_DHI: if (take) begin
          disp_q[15:8] <= in_byte;
          len_q <= len_q + 3'd1;
          st <= (icnt_q != 2'd0) ? S_ILO : S_EMIT;
        end
        S_ILO: if (take) begin
          imm_q <= sext_q ? b_sx : b_zx;
          len_q <= len_q + 3'd1;
          st <= (icnt_q == 2'd2) ? S_IHI : S_EMIT;
        end
        S_IHI: if (take) begin
          imm_q[15:8] <= in_byte;
          len_q <= len_q + 3'd1;
          st <= S_EMIT;
        end
        S_EMIT: if (out_ready) st <= S_OPC;
        default: st <= S_OPC;
      endcase
    end
  end

  logic [2:0] seen_q;
  always_ff @(posedge clk) begin
    if (rst) seen_q <= '0;
    else if (out_valid && out_ready) seen_q <= '0;
    else if (take) seen_q <= seen_q + 3'd1;
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> (!out_valid && in_ready));
  p_inc_len_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_err && q_inc) |-> (out_len == 3'd1));
  p_sext_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_s && out_w) |-> (out_imm[15:8] == {8{out_imm[7]}}));
  p_err_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> (out_len == 3'd1 && !out_has_modrm));
  p_no_take_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_imm) && $stable(out_disp) && $stable(out_len)));
  p_len_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_len == seen_q && out_len >= 3'd1 && out_len <= 3'd6));
endmodule

// File: tb/instr_len_parser_tb.sv
module instr_len_parser_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic out_ready = 1'b0;
  logic in_ready, out_valid, out_err, out_has_modrm, out_d, out_w, out_s;
  logic [7:0] out_opcode;
  logic [2:0] out_len, out_reg, out_rm;
  logic [1:0] out_mod;
  logic [15:0] out_disp, out_imm;

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_len_parser u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_opcode(out_opcode), .out_len(out_len),
    .out_err(out_err), .out_has_modrm(out_has_modrm), .out_d(out_d), .out_w(out_w), .out_s(out_s),
    .out_mod(out_mod), .out_reg(out_reg), .out_rm(out_rm), .out_disp(out_disp), .out_imm(out_imm)
  );

  typedef struct packed {
    logic [47:0] b;
    logic [2:0]  n;
    logic        err, has, w, d, s;
    logic [2:0]  rg;
    logic [1:0]  md;
    logic [2:0]  rm;
    logic [15:0] disp, imm;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{48'h40,           3'd1, 1'b0,1'b0,1'b1,1'b0,1'b0, 3'd0,2'd0,3'd0, 16'h0000,16'h0000},
    '{48'h47,           3'd1, 1'b0,1'b0,1'b1,1'b0,1'b0, 3'd7,2'd0,3'd0, 16'h0000,16'h0000},
    '{48'hD801,         3'd2, 1'b0,1'b1,1'b1,1'b0,1'b0, 3'd3,2'd3,3'd0, 16'h0000,16'h0000},
    '{48'hF04702,       3'd3, 1'b0,1'b1,1'b0,1'b1,1'b0, 3'd0,2'd1,3'd7, 16'hFFF0,16'h0000},
    '{48'h1234872B,     3'd4, 1'b0,1'b1,1'b1,1'b1,1'b0, 3'd0,2'd2,3'd7, 16'h1234,16'h0000},
    '{48'h5678063A,     3'd4, 1'b0,1'b1,1'b0,1'b1,1'b0, 3'd0,2'd0,3'd6, 16'h5678,16'h0000},
    '{48'h043B,         3'd2, 1'b0,1'b1,1'b1,1'b1,1'b0, 3'd0,2'd0,3'd4, 16'h0000,16'h0000},
    '{48'h7FC380,       3'd3, 1'b0,1'b1,1'b0,1'b0,1'b0, 3'd0,2'd3,3'd3, 16'h0000,16'h007F},
    '{48'hABCD00108781, 3'd6, 1'b0,1'b1,1'b1,1'b0,1'b0, 3'd0,2'd2,3'd7, 16'h0010,16'hABCD},
    '{48'h8012343E83,   3'd5, 1'b0,1'b1,1'b1,1'b0,1'b1, 3'd7,2'd0,3'd6, 16'h1234,16'hFF80},
    '{48'h05F983,       3'd3, 1'b0,1'b1,1'b1,1'b0,1'b1, 3'd7,2'd3,3'd1, 16'h0000,16'h0005},
    '{48'h9AB0,         3'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 3'd0,2'd0,3'd0, 16'h0000,16'h009A},
    '{48'h1234BB,       3'd3, 1'b0,1'b0,1'b1,1'b0,1'b0, 3'd3,2'd0,3'd0, 16'h0000,16'h1234},
    '{48'hC0FE,         3'd2, 1'b0,1'b1,1'b0,1'b0,1'b0, 3'd0,2'd3,3'd0, 16'h0000,16'h0000},
    '{48'h8047FF,       3'd3, 1'b0,1'b1,1'b1,1'b0,1'b0, 3'd0,2'd1,3'd7, 16'hFF80,16'h0000},
    '{48'h82,           3'd1, 1'b1,1'b0,1'b0,1'b0,1'b0, 3'd0,2'd0,3'd0, 16'h0000,16'h0000},
    '{48'h41,           3'd1, 1'b0,1'b0,1'b1,1'b0,1'b0, 3'd1,2'd0,3'd0, 16'h0000,16'h0000},
    '{48'h0F,           3'd1, 1'b1,1'b0,1'b0,1'b0,1'b0, 3'd0,2'd0,3'd0, 16'h0000,16'h0000},
    '{48'h04,           3'd1, 1'b1,1'b0,1'b0,1'b0,1'b0, 3'd0,2'd0,3'd0, 16'h0000,16'h0000},
    '{48'h9AB3,         3'd2, 1'b0,1'b0,1'b0,1'b0,1'b0, 3'd3,2'd0,3'd0, 16'h0000,16'h009A}
  };

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic take_rec;
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk);
    #1;
    out_ready = 1'b0;
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.err) return "R8";
    if (v.b[7:3] == 5'b01000) return "R2";
    if (v.b[7:4] == 4'b1011) return "R6";
    if (v.b[7:2] == 6'b100000) return "R5";
    if (v.b[7:1] == 7'b1111111) return "R7";
    if (v.md == 2'd1 || v.md == 2'd2 || (v.md == 2'd0 && v.rm == 3'd6)) return "R4";
    return "R3";
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready, "R1 in_ready after reset", in_ready, 1);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string t;
      v = TBL[i];
      t = tag_of(v);
      for (int k = 0; k < 6; k++)
        if (k < int'(v.n)) send(v.b[8*k +: 8]);
      @(negedge clk);
      while (!out_valid) @(negedge clk);
      chk(out_len == v.n, "R10 length", out_len, v.n);
      chk(out_err == v.err, {t, " error flag"}, out_err, v.err);
      if (!v.err) begin
        chk(out_has_modrm == v.has, {t, " addressing byte"}, out_has_modrm, v.has);
        chk(out_w == v.w, {t, " w"}, out_w, v.w);
        chk(out_d == v.d, {t, " d"}, out_d, v.d);
        chk(out_s == v.s, {t, " s"}, out_s, v.s);
        chk(out_reg == v.rg, {t, " reg"}, out_reg, v.rg);
        chk(out_mod == v.md, {t, " mod"}, out_mod, v.md);
        chk(out_rm == v.rm, {t, " rm"}, out_rm, v.rm);
        chk(out_disp == v.disp, {t, " disp"}, out_disp, v.disp);
        chk(out_imm == v.imm, {t, " imm"}, out_imm, v.imm);
      end else begin
        chk(!out_has_modrm, "R8 no addressing byte", out_has_modrm, 0);
      end
      take_rec();
    end

    // R9: stall with a new byte waiting on the input
    send(8'h40);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte = 8'h47;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(out_valid, "R9 record held", out_valid, 1);
      chk(!in_ready, "R9 input blocked", in_ready, 0);
      chk(out_reg == 3'd0, "R9 record stable", out_reg, 0);
    end
    out_ready = 1'b1;
    @(posedge clk);
    #1 out_ready = 1'b0;
    @(negedge clk);
    chk(in_ready, "R9 input accepted after release", in_ready, 1);
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid && out_reg == 3'd7 && out_len == 3'd1, "R9 waiting byte parsed once", {out_valid, out_reg}, 4'hF);
    take_rec();
    @(negedge clk);
    chk(!out_valid, "R9 no duplicate record", out_valid, 0);

    // R1: reset in the middle of an instruction
    send(8'h81);
    send(8'h87);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && in_ready, "R1 mid-instruction reset", {out_valid, in_ready}, 2'b01);
    send(8'h40);
    @(negedge clk);
    chk(out_valid && out_len == 3'd1 && !out_err, "R1 fresh opcode after reset", out_len, 1);
    take_rec();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule